// File: doc/BRIEF.md
# SWD Connection and Line Reset Sequencer

This block brings a debug port that can speak either JTAG or SWD into SWD mode and re-establishes packet framing on the wire. After a one-cycle start pulse, it drives a bit-level stream on the data pin while it gates the debug clock on. The stream has four parts: a long run of ones, the 16-bit switch pattern sent least-significant bit first, a second long run of ones, and a short run of zeros that leaves the bus idle.

The second run of ones returns the port to line reset even if it was already in SWD mode before the pattern. After that the bit-level drive stops. The block then asks an external transaction serializer to read the identification register of the debug port. It compares the acknowledge and the returned word with an expected value supplied on an input. The result is a done flag that stays set, with an ok or a fail flag beside it, until the next start.

Top module: `swd_conn_seq`

## Requirements
- R1: Out of reset, busy, done, ok, fail, the clock enable, the read request and the data pin are all low.
- R2: In the cycle after an accepted start, the clock enable rises. The data pin is then high for RESET_LEN (default 56) consecutive cycles.
- R3: Next, for 16 cycles, the pin carries the switch pattern 16'hE79E, bit 0 first.
- R4: A second run of RESET_LEN ones follows the pattern directly.
- R5: Then the pin is low for IDLE_LEN (default 8) cycles, after which the clock enable drops.
- R6: Once the clock enable drops, a read request is raised with apndp=0, rnw=1 and addr=2'b00 (identification register). It stays raised until a response arrives. During the request the pin stays low and the clock enable stays off.
- R7: A response with acknowledge 3'b001 and data equal to exp_id ends the sequence with done=1, ok=1, fail=0 and busy=0.
- R8: A response with acknowledge 3'b001 and data different from exp_id ends with done=1, fail=1, ok=0.
- R9: An acknowledge of 3'b010 (wait) or 3'b100 (fault) ends with done=1, fail=1, ok=0, whatever the data.
- R10: A start pulse while busy is ignored: the stream keeps its length and content.
- R11: A start after done clears done, ok and fail and runs the whole sequence again.
- R12: Busy is high from the cycle after an accepted start until the cycle in which done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin the connection sequence |
| exp_id | input | 32 | Expected identification word |
| swdio_o | output | 1 | Level to drive on the debug data pin |
| swclk_en | output | 1 | Enables the debug clock during the bit stream |
| cmd_valid | output | 1 | Read request to the transaction serializer |
| cmd_apndp | output | 1 | Request targets the access port when 1 (always 0 here) |
| cmd_rnw | output | 1 | Request is a read when 1 |
| cmd_addr | output | 2 | Register address bits [3:2] |
| rsp_valid | input | 1 | One-cycle response strobe from the serializer |
| rsp_ack | input | 3 | Acknowledge received |
| rsp_data | input | 32 | Word read back |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until next start |
| ok | output | 1 | Finished with a matching identification word |
| fail | output | 1 | Finished with a bad acknowledge or mismatch |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of the bit stream. A block that wrongly restarts would still emit a well-formed stream, only a longer one. To catch this, the bench pulses start partway through the first run of ones and records every clocked bit. It then checks the exact length of the stream as well as its content. The response strobe is also delayed by several cycles, so the bench can confirm that the request holds steady and the bit-level drive stays silent while the serializer is busy.

// File: rtl/swd_conn_seq.sv
module swd_conn_seq #(
  parameter int RESET_LEN = 56,
  parameter int IDLE_LEN = 8,
  parameter logic [15:0] SEL_PAT = 16'hE79E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] exp_id,
  output logic        swdio_o,
  output logic        swclk_en,
  output logic        cmd_valid,
  output logic        cmd_apndp,
  output logic        cmd_rnw,
  output logic [1:0]  cmd_addr,
  input  logic        rsp_valid,
  input  logic [2:0]  rsp_ack,
  input  logic [31:0] rsp_data,
  output logic        busy,
  output logic        done,
  output logic        ok,
  output logic        fail
);
  localparam int MAXLEN = (RESET_LEN > 16) ? RESET_LEN : 16;
  localparam int CW = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RESET_LEN - 1);
  localparam logic [CW-1:0] SEL_LAST = CW'(15);
  localparam logic [CW-1:0] ZER_LAST = CW'(IDLE_LEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_RST1, S_SEL, S_RST2, S_ZERO, S_READ, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          pass;

  assign swclk_en  = (st == S_RST1) || (st == S_SEL) || (st == S_RST2) || (st == S_ZERO);
  assign swdio_o   = (st == S_RST1) || (st == S_RST2) || ((st == S_SEL) && SEL_PAT[cnt[3:0]]);
  assign cmd_valid = (st == S_READ);
  assign cmd_apndp = 1'b0;
  assign cmd_rnw   = 1'b1;
  assign cmd_addr  = 2'b00;
  assign busy      = (st != S_IDLE) && (st != S_FIN);
  assign done      = (st == S_FIN);
  assign ok        = done && pass;
  assign fail      = done && !pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pass <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_FIN: if (start) begin
          st   <= S_RST1;
          cnt  <= '0;
          pass <= 1'b0;
        end
        S_RST1: if (cnt == RST_LAST) begin st <= S_SEL;  cnt <= '0; end else cnt <= cnt + 1'b1;
        S_SEL:  if (cnt == SEL_LAST) begin st <= S_RST2; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_RST2: if (cnt == RST_LAST) begin st <= S_ZERO; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_ZERO: if (cnt == ZER_LAST) begin st <= S_READ; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_READ: if (rsp_valid) begin
          st   <= S_FIN;
          pass <= (rsp_ack == 3'b001) && (rsp_data == exp_id);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_status_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && fail) && !(done && busy));

  p_read_after_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swclk_en) |-> cmd_valid && !$past(swdio_o));

  p_done_by_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_valid && rsp_valid));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cmd_valid) |=> busy);

  p_req_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !swclk_en && !swdio_o);
endmodule

// File: tb/tb_swd_conn_seq.sv
module tb_swd_conn_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RLEN = 56;
  localparam int ZLEN = 8;
  localparam int TOTAL = 2 * RLEN + 16 + ZLEN;
  localparam logic [15:0] PAT = 16'hE79E;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] exp_id = 32'h2BA01477;
  logic rsp_valid = 1'b0;
  logic [2:0] rsp_ack = 3'b000;
  logic [31:0] rsp_data = '0;
  logic swdio_o, swclk_en, cmd_valid, cmd_apndp, cmd_rnw, busy, done, ok, fail;
  logic [1:0] cmd_addr;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swd_conn_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_id(exp_id),
    .swdio_o(swdio_o), .swclk_en(swclk_en), .cmd_valid(cmd_valid),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
    .busy(busy), .done(done), .ok(ok), .fail(fail));

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic exp_bit(input int i);
    if (i < RLEN) return 1'b1;
    if (i < RLEN + 16) return PAT[i - RLEN];
    if (i < 2 * RLEN + 16) return 1'b1;
    return 1'b0;
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk({busy, done, ok, fail, swclk_en, cmd_valid, swdio_o} == 7'b0, "R1 reset outputs",
        {busy, done, ok, fail, swclk_en, cmd_valid, swdio_o}, 0);
  endtask

  // Runs the bit stream, optionally pulsing start midway (R10), then checks the request (R6)
  task automatic run_stream(input bit poke);
    int e2 = 0, e3 = 0, e4 = 0, e5 = 0, ebusy = 0, len = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !ok && !fail, "R11 status cleared", {done, ok, fail}, 0);
    for (int i = 0; i < TOTAL + 4; i++) begin
      if (i > 0) @(negedge clk);
      start = (poke && i == 30);
      if (swclk_en) begin
        len++;
        if (swdio_o !== exp_bit(i)) begin
          if (i < RLEN) e2++;
          else if (i < RLEN + 16) e3++;
          else if (i < 2 * RLEN + 16) e4++;
          else e5++;
        end
      end
      if (!busy) ebusy++;
    end
    start = 1'b0;
    chk(e2 == 0, "R2 first line reset", e2, 0);
    chk(e3 == 0, "R3 select pattern", e3, 0);
    chk(e4 == 0, "R4 second line reset", e4, 0);
    chk(e5 == 0, "R5 idle zeros", e5, 0);
    chk(len == TOTAL, poke ? "R10 stream length with start while busy" : "R5 stream length", len, TOTAL);
    chk(ebusy == 0, "R12 busy during sequence", ebusy, 0);
    chk(cmd_valid && !cmd_apndp && cmd_rnw && cmd_addr == 2'b00 && !swclk_en && !swdio_o,
        "R6 identification read request",
        {cmd_valid, cmd_apndp, cmd_rnw, cmd_addr, swclk_en, swdio_o}, 7'b1010000);
  endtask

  task automatic respond(input logic [2:0] ack, input logic [31:0] data, input bit exp_ok, input string tag);
    rsp_valid = 1'b1; rsp_ack = ack; rsp_data = data;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(done && !busy && ok == exp_ok && fail == !exp_ok, tag,
        {done, busy, ok, fail}, {1'b1, 1'b0, exp_ok, !exp_ok});
    @(negedge clk);
    chk(done && ok == exp_ok && fail == !exp_ok, {tag, " held"}, {done, ok, fail}, {1'b1, exp_ok, !exp_ok});
  endtask

  task automatic test_match();
    run_stream(1'b0);
    respond(3'b001, 32'h2BA01477, 1'b1, "R7 match");
  endtask

  task automatic test_start_busy();
    exp_id = 32'h0BC11477;
    run_stream(1'b1);
    respond(3'b001, 32'h0BC11477, 1'b1, "R7 match second id");
  endtask

  task automatic test_mismatch();
    run_stream(1'b0);
    respond(3'b001, 32'h0BC11476, 1'b0, "R8 mismatch");
  endtask

  task automatic test_wait_fault();
    run_stream(1'b0);
    respond(3'b010, exp_id, 1'b0, "R9 wait ack");
    run_stream(1'b0);
    respond(3'b100, exp_id, 1'b0, "R9 fault ack");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_match();
    test_start_busy();
    test_mismatch();
    test_wait_fault();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule